// File: doc/BRIEF.md
# Interleaved Pipelined Multiply-Accumulate Engine

This block computes signed dot products over streams of sample/coefficient pairs, for example as the arithmetic core of an FIR filter. One pair can enter on every clock cycle through a valid/ready input. A `in_last` flag on the final beat of a vector closes that vector. Each pair is multiplied in a two-stage pipelined multiplier. The product then goes through an accumulate path whose latency is `LAT` clock edges.

An accumulate depends on the result of the one before it. A single accumulator behind an `LAT`-cycle adder could therefore take a new product only once every `LAT` cycles. To avoid that, the block keeps `LAT` independent partial sums. Beat number k of a vector (counting from 0) goes to partial `k mod LAT`. A given partial is therefore revisited no sooner than `LAT` cycles later, by which time its previous update has been written back.

After the last product of a vector has been written back, one reduction cycle adds all partials together. The total is presented on `out_valid`/`out_data` for exactly one cycle.

Back-pressure rules:
- `in_ready` is high while the block is taking beats of a vector.
- `in_ready` drops after the beat carrying `in_last` is accepted, and stays low until the result is presented.
- A beat is consumed only on a clock edge where `in_valid` and `in_ready` are both high. A beat offered while `in_ready` is low stays pending on the inputs.
- The output has no back-pressure: the result pulse must be taken when it appears.

Top module: `ilv_mac`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0, and all partial sums are zero, so the first result contains only the first vector's products.
- R2: With `WIDE_ACC`=1 (64-bit result), `out_data` equals the sum of the signed 32x32 products of the vector's beats, taken modulo 2^64 (two's-complement wrap on overflow).
- R3: While a vector is being taken, `in_ready` stays high after every accepted beat that is not marked last, so one beat per cycle is accepted with no stall.
- R4: After the beat marked `in_last` is accepted, `in_ready` is low until the result appears. `out_valid` is high for exactly one cycle per vector.
- R5: `out_valid` is high in the cycle that follows the 2+`LAT`-th clock edge after the edge that accepted the last beat.
- R6: `in_ready` returns high in the same cycle in which `out_valid` is high, and not earlier.
- R7: Vectors shorter than `LAT` (1 to `LAT`-1 beats), and vectors whose length is not a multiple of `LAT`, give the correct result. Partials that received no product contribute zero.
- R8: `auto_clear` is sampled on the edge that registers a result. When it is 1, all partials are zeroed on that edge. When it is 0, the partials are kept, so the next result is the previous result plus the new vector's dot product.
- R9: With `WIDE_ACC`=0, `out_data` is 32 bits wide and equals the low 32 bits of the R2 sum.
- R10: Idle cycles with `in_valid` low between beats, and beats held pending while `in_ready` is low, do not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_clear | input | 1 | 1: zero the partials after each result; 0: carry them into the next vector |
| in_valid | input | 1 | A sample/coefficient beat is offered |
| in_ready | output | 1 | Block accepts a beat on this edge |
| in_sample | input | DATA_W | Signed sample operand |
| in_coef | input | DATA_W | Signed coefficient operand |
| in_last | input | 1 | Beat is the final one of its vector |
| out_valid | output | 1 | One-cycle pulse marking a finished dot product |
| out_data | output | ACC_W | Result: 2*DATA_W bits when WIDE_ACC=1, DATA_W bits otherwise |

## Verification
The bench builds two instances with `LAT`=4 and drives them with identical stimulus. One uses `WIDE_ACC`=1 and the other `WIDE_ACC`=0, so both result widths are checked against a single 64-bit reference sum. With `LAT`=4, vectors of one to three beats leave some partials untouched, and lengths of five or more make the rotation wrap mid-vector. Operands of 0x80000000 make four products add up to exactly 2^64, which checks the 64-bit wrap while the narrow result shows the truncation.

// File: rtl/ilv_mac_pkg.sv
package ilv_mac_pkg;
  // register stages between an accepted beat and the adder input
  localparam int MUL_STAGES = 2;

  typedef enum logic {CT_TAKE, CT_HOLD} ctl_state_e;

  function automatic int unsigned wrap_inc(int unsigned v, int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/ilv_mac_ctrl.sv
module ilv_mac_ctrl
  import ilv_mac_pkg::*;
#(
  parameter int LAT   = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic             fin,
  output logic             in_ready,
  output logic             take,
  output logic [IDX_W-1:0] slot
);
  ctl_state_e       state_q;
  logic [IDX_W-1:0] slot_q;

  assign in_ready = (state_q == CT_TAKE);
  assign take     = in_valid && in_ready;
  assign slot     = slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CT_TAKE;
      slot_q  <= '0;
    end else begin
      case (state_q)
        CT_TAKE: if (take) begin
          if (in_last) begin
            slot_q  <= '0;
            state_q <= CT_HOLD;
          end else begin
            slot_q <= IDX_W'(wrap_inc(32'(slot_q), LAT));
          end
        end
        CT_HOLD: if (fin) state_q <= CT_TAKE;
        default: state_q <= CT_TAKE;
      endcase
    end
  end
endmodule

// File: rtl/ilv_mac_mul.sv
module ilv_mac_mul #(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 64,
  parameter int IDX_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [IDX_W-1:0] slot,
  input  logic             last,
  output logic             p_valid,
  output logic [ACC_W-1:0] p_data,
  output logic [IDX_W-1:0] p_slot,
  output logic             p_last
);
  logic              s1_v, s1_last;
  logic [DATA_W-1:0] s1_a, s1_b;
  logic [IDX_W-1:0]  s1_slot;
  logic signed [ACC_W-1:0] xa, xb;

  // sign-extend to the result width; the low ACC_W bits of the product
  // are the same as those of the full-width product
  assign xa = ACC_W'($signed(s1_a));
  assign xb = ACC_W'($signed(s1_b));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_last <= 1'b0;
      s1_a    <= '0;
      s1_b    <= '0;
      s1_slot <= '0;
      p_valid <= 1'b0;
      p_last  <= 1'b0;
      p_data  <= '0;
      p_slot  <= '0;
    end else begin
      s1_v    <= take;
      s1_last <= take && last;
      s1_a    <= a;
      s1_b    <= b;
      s1_slot <= slot;
      p_valid <= s1_v;
      p_last  <= s1_last;
      p_data  <= xa * xb;
      p_slot  <= s1_slot;
    end
  end
endmodule

// File: rtl/ilv_mac_acc.sv
module ilv_mac_acc #(
  parameter int ACC_W = 64,
  parameter int LAT   = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_clear,
  input  logic             p_valid,
  input  logic [ACC_W-1:0] p_data,
  input  logic [IDX_W-1:0] p_slot,
  input  logic             p_last,
  output logic             fin,
  output logic             out_valid,
  output logic [ACC_W-1:0] out_data
);
  logic [ACC_W-1:0] part [LAT];
  logic [ACC_W-1:0] s0_sum, total;
  logic             w_v, w_last;
  logic [ACC_W-1:0] w_sum;
  logic [IDX_W-1:0] w_slot;
  logic             fin_q;

  assign s0_sum = part[p_slot] + p_data;
  assign fin    = fin_q;

  // accumulate path: LAT edges from reading a partial to writing it back
  generate
    if (LAT == 1) begin : g_direct
      assign w_v    = p_valid;
      assign w_last = p_last;
      assign w_sum  = s0_sum;
      assign w_slot = p_slot;
    end else begin : g_delay
      logic             dv   [LAT-1];
      logic             dl   [LAT-1];
      logic [ACC_W-1:0] ds   [LAT-1];
      logic [IDX_W-1:0] dsl  [LAT-1];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < LAT-1; i++) begin
            dv[i]  <= 1'b0;
            dl[i]  <= 1'b0;
            ds[i]  <= '0;
            dsl[i] <= '0;
          end
        end else begin
          dv[0]  <= p_valid;
          dl[0]  <= p_valid && p_last;
          ds[0]  <= s0_sum;
          dsl[0] <= p_slot;
          for (int i = 1; i < LAT-1; i++) begin
            dv[i]  <= dv[i-1];
            dl[i]  <= dl[i-1];
            ds[i]  <= ds[i-1];
            dsl[i] <= dsl[i-1];
          end
        end
      end
      assign w_v    = dv[LAT-2];
      assign w_last = dl[LAT-2];
      assign w_sum  = ds[LAT-2];
      assign w_slot = dsl[LAT-2];
    end
  endgenerate

  always_comb begin
    total = '0;
    for (int k = 0; k < LAT; k++) total = total + part[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < LAT; k++) part[k] <= '0;
      fin_q     <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      fin_q     <= w_v && w_last;
      out_valid <= fin_q;
      if (fin_q) out_data <= total;
      if (fin_q && auto_clear) begin
        for (int k = 0; k < LAT; k++) part[k] <= '0;
      end else if (w_v) begin
        part[w_slot] <= w_sum;
      end
    end
  end
endmodule

// File: rtl/ilv_mac.sv
module ilv_mac #(
  parameter int DATA_W   = 32,
  parameter int LAT      = 4,
  parameter bit WIDE_ACC = 1'b1,
  localparam int ACC_W   = WIDE_ACC ? 2*DATA_W : DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_clear,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_sample,
  input  logic [DATA_W-1:0] in_coef,
  input  logic              in_last,
  output logic              out_valid,
  output logic [ACC_W-1:0]  out_data
);
  localparam int IDX_W = (LAT > 1) ? $clog2(LAT) : 1;

  logic             take, fin;
  logic [IDX_W-1:0] slot;
  logic             p_valid, p_last;
  logic [ACC_W-1:0] p_data;
  logic [IDX_W-1:0] p_slot;

  ilv_mac_ctrl #(.LAT(LAT), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .fin(fin), .in_ready(in_ready), .take(take), .slot(slot)
  );

  ilv_mac_mul #(.DATA_W(DATA_W), .ACC_W(ACC_W), .IDX_W(IDX_W)) mul_i (
    .clk(clk), .rst_n(rst_n), .take(take), .a(in_sample), .b(in_coef),
    .slot(slot), .last(in_last), .p_valid(p_valid), .p_data(p_data),
    .p_slot(p_slot), .p_last(p_last)
  );

  ilv_mac_acc #(.ACC_W(ACC_W), .LAT(LAT), .IDX_W(IDX_W)) acc_i (
    .clk(clk), .rst_n(rst_n), .auto_clear(auto_clear), .p_valid(p_valid),
    .p_data(p_data), .p_slot(p_slot), .p_last(p_last), .fin(fin),
    .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: rtl/ilv_mac_chk.sv
module ilv_mac_chk
  import ilv_mac_pkg::*;
#(
  parameter int LAT = 4
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic in_last,
  input logic out_valid
);
  logic [15:0] since_last;
  logic        armed;

  // counts edges since the last beat of a vector was accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_last <= '0;
      armed      <= 1'b0;
    end else if (in_valid && in_ready && in_last) begin
      since_last <= '0;
      armed      <= 1'b1;
    end else begin
      if (out_valid) armed <= 1'b0;
      if (since_last != 16'hffff) since_last <= since_last + 16'd1;
    end
  end

  p_stream_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_last |=> in_ready);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_last |=> !in_ready);

  p_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> armed && (since_last == 16'(MUL_STAGES + LAT)));

  p_reopen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> out_valid);

  p_ready_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);
endmodule

bind ilv_mac ilv_mac_chk #(.LAT(LAT)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .out_valid(out_valid)
);

// File: tb/ilv_mac_tb_top.sv
module ilv_mac_tb_top;
  localparam int LAT = 4;
  // counter difference between the cycle that offers the last beat
  // and the cycle in which the result is visible: 1 accept edge + 2 + LAT
  localparam int EDGE_GAP = LAT + 3;

  logic        clk = 1'b0;
  logic        rst_n, auto_clear, in_valid, in_last;
  logic [31:0] in_sample, in_coef;
  logic        rdy_w, rdy_n, ov_w, ov_n;
  logic [63:0] od_w;
  logic [31:0] od_n;

  int total = 0;
  int bad   = 0;
  int unsigned cyc = 0;
  longint unsigned exp_q[$];
  int unsigned     last_q[$];
  longint unsigned carry = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ilv_mac #(.DATA_W(32), .LAT(LAT), .WIDE_ACC(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .auto_clear(auto_clear), .in_valid(in_valid),
    .in_ready(rdy_w), .in_sample(in_sample), .in_coef(in_coef),
    .in_last(in_last), .out_valid(ov_w), .out_data(od_w)
  );

  ilv_mac #(.DATA_W(32), .LAT(LAT), .WIDE_ACC(1'b0)) dut_n (
    .clk(clk), .rst_n(rst_n), .auto_clear(auto_clear), .in_valid(in_valid),
    .in_ready(rdy_n), .in_sample(in_sample), .in_coef(in_coef),
    .in_last(in_last), .out_valid(ov_n), .out_data(od_n)
  );

  task automatic chk(input bit ok, input string req,
                     input longint unsigned act, input longint unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // driver: offers one vector, pushes its expected result into the scoreboard
  task automatic send_vec(input int len, input int stall_pct, input bit extreme);
    longint unsigned dot = 0;
    longint unsigned e;
    int waits = 0;
    for (int i = 0; i < len; i++) begin
      logic [31:0] a, b;
      a = extreme ? 32'h8000_0000 : $urandom;
      b = extreme ? 32'h8000_0000 : $urandom;
      @(negedge clk);
      if (i > 0 && stall_pct > 0)
        while ($urandom_range(99) < stall_pct) begin
          in_valid = 1'b0;
          @(negedge clk);
        end
      in_valid  = 1'b1;
      in_sample = a;
      in_coef   = b;
      in_last   = (i == len - 1);
      while (!rdy_w) begin
        if (i > 0) waits++;
        @(negedge clk);
      end
      dot += longint'($signed(a)) * longint'($signed(b));
      if (i == len - 1) last_q.push_back(cyc);
    end
    @(negedge clk);
    chk(rdy_w == 1'b0, "R4 in_ready low after last beat", 64'(rdy_w), 0);
    in_valid = 1'b0;
    in_last  = 1'b0;
    if (stall_pct == 0) chk(waits == 0, "R3 no stall inside vector", 64'(waits), 0);
    e = carry + dot;
    exp_q.push_back(e);
    carry = auto_clear ? 64'd0 : e;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (rst_n && (ov_w || ov_n)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected result", od_w, 0);
      end else begin
        longint unsigned e;
        int unsigned l;
        e = exp_q.pop_front();
        l = last_q.pop_front();
        chk(od_w == e, "R2/R7/R8/R10 wide result", od_w, e);
        chk(od_n == e[31:0], "R9 narrow result", 64'(od_n), 64'(e[31:0]));
        chk(ov_w && ov_n, "R9 both results aligned", 64'({ov_w, ov_n}), 3);
        chk(cyc - l == EDGE_GAP, "R5 result latency", 64'(cyc - l), EDGE_GAP);
        chk(rdy_w == 1'b1, "R6 ready with result", 64'(rdy_w), 1);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 0);
    summary();
  end

  initial begin
    rst_n = 1'b0; auto_clear = 1'b1; in_valid = 1'b0; in_last = 1'b0;
    in_sample = '0; in_coef = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    chk(rdy_w == 1'b1, "R1 in_ready after reset", 64'(rdy_w), 1);
    chk(ov_w == 1'b0, "R1 out_valid after reset", 64'(ov_w), 0);

    send_vec(6, 0, 1'b0);                 // R2, R3: plain vector
    for (int n = 1; n < LAT; n++) send_vec(n, 0, 1'b0);   // R7 short
    send_vec(4, 0, 1'b1);                 // R2: 4 * 2^62 wraps to 0
    send_vec(5, 0, 1'b1);                 // R2: 2^62
    for (int v = 0; v < 20; v++)          // R10: random lengths, stalls
      send_vec(1 + int'($urandom_range(19)), 40, 1'b0);
    wait_idle();

    auto_clear = 1'b0;                    // R8: running total across vectors
    send_vec(3, 0, 1'b0);
    send_vec(7, 30, 1'b0);
    send_vec(2, 0, 1'b0);
    wait_idle();
    auto_clear = 1'b1;
    send_vec(5, 0, 1'b0);                 // R8: includes carry, then clears
    send_vec(3, 0, 1'b0);                 // R8: own dot product only
    send_vec(40, 0, 1'b0);                // R3: long unstalled vector
    wait_idle();
    chk(exp_q.size() == 0, "R4 every vector produced a result",
        64'(exp_q.size()), 0);
    summary();
  end
endmodule